// File: doc/BRIEF.md
# Recoded Decimal Partial Product Generator

This block turns a BCD multiplicand and one BCD multiplier digit into a single partial product of a parallel decimal multiplier. It does not build every multiple from one to nine times the multiplicand. It splits the digit into a part weighted by five and a small signed remainder, so the only multiples it needs are double and quintuple, plus a one-digit shift for ten times. Each of these is formed digit by digit with no carry ripple. The remainder may be negative. In that case its multiple is negated in ten's complement, and a single decimal adder/subtractor combines the two terms.

The multiplicand and digit are sampled on a rising clock edge. The partial product appears on the output register one cycle later, as a ten's-complement BCD number two digits wider than the multiplicand. A later reduction stage aligns and sums one such value per multiplier digit.

Top module: `decimal_pp_gen`

## Requirements
- R1: One clock edge after `multiplicand` = X and `digit` = Y (0..9) are sampled, `product` holds X*Y as DIGITS+2 BCD digits, with digit k in bits 4k+3..4k and the least significant digit in bits 3..0.
- R2: While `rstN` is low, `product` is all zeros, whatever the inputs are.
- R3: Every 4-bit digit of `product` is always in the range 0..9.
- R4: Digits 8 and 9 are formed as ten times X minus two times X and ten times X minus X; the result equals 8X and 9X.
- R5: Digits 3 and 4 are formed as five times X minus two times X and five times X minus X, with the negative term in ten's complement; the result equals 3X and 4X.
- R6: A digit of 0 gives an all-zero product for every multiplicand.
- R7: A digit of 1 gives a product equal to the multiplicand extended with two leading zero digits.
- R8: The most significant digit of `product` is always 0, so the partial product is never negative and never overflows.
- R9: Doubling handles an all-nines multiplicand, where every digit generates a carry at once: Y = 2 with X = 99..9 gives 199..98.
- R10: Quintupling handles an all-nines multiplicand: Y = 5 with X = 99..9 gives 499..95.
- R11: Digit codes 10 to 15 are not decimal digits and give an all-zero product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| multiplicand | input | 4*DIGITS | BCD multiplicand X, least significant digit in bits 3..0 |
| digit | input | 4 | BCD multiplier digit Y |
| product | output | 4*(DIGITS+2) | Registered ten's-complement BCD partial product |

## Verification
The bench sweeps every three-digit multiplicand against every 4-bit digit code. Each output is compared with the arithmetic product, so each recoding path is tried on the full range of X. Digits 0 to 2 use only a positive lower term. Digits 3, 4, 8 and 9 use the subtract path and show up complement or carry-in errors. Digits 5 to 7 use the quintuple with a non-negative remainder. The all-nines multiplicand drives every doubling and halving carry at the same time, and codes above nine show whether invalid digits are suppressed.

// File: rtl/ppgen_pkg.sv
package ppgen_pkg;

  localparam int DIGIT_W = 4;

  // Strobes from the recoder to the datapath.
  // upSel : one-hot upper term  [0]=zero, [1]=5X, [2]=10X
  // loSel : one-hot lower magnitude [0]=zero, [1]=X, [2]=2X
  // loNeg : lower term is subtracted
  typedef struct packed {
    logic [2:0] upSel;
    logic [2:0] loSel;
    logic       loNeg;
  } ppCtrl_t;

endpackage

// File: rtl/ppgen_recode.sv
module ppgen_recode
  import ppgen_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit,
  output ppCtrl_t            ctrl
);

  always_comb begin
    ctrl = '0;
    case (digit)
      4'd0: begin ctrl.upSel = 3'b001; ctrl.loSel = 3'b001; end
      4'd1: begin ctrl.upSel = 3'b001; ctrl.loSel = 3'b010; end
      4'd2: begin ctrl.upSel = 3'b001; ctrl.loSel = 3'b100; end
      4'd3: begin ctrl.upSel = 3'b010; ctrl.loSel = 3'b100; ctrl.loNeg = 1'b1; end
      4'd4: begin ctrl.upSel = 3'b010; ctrl.loSel = 3'b010; ctrl.loNeg = 1'b1; end
      4'd5: begin ctrl.upSel = 3'b010; ctrl.loSel = 3'b001; end
      4'd6: begin ctrl.upSel = 3'b010; ctrl.loSel = 3'b010; end
      4'd7: begin ctrl.upSel = 3'b010; ctrl.loSel = 3'b100; end
      4'd8: begin ctrl.upSel = 3'b100; ctrl.loSel = 3'b100; ctrl.loNeg = 1'b1; end
      4'd9: begin ctrl.upSel = 3'b100; ctrl.loSel = 3'b010; ctrl.loNeg = 1'b1; end
      default: begin ctrl.upSel = 3'b001; ctrl.loSel = 3'b001; end  // R11
    endcase
  end

endmodule

// File: rtl/ppgen_datapath.sv
module ppgen_datapath
  import ppgen_pkg::*;
#(
  parameter int DIGITS = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [DIGIT_W*DIGITS-1:0]      multiplicand,
  input  ppCtrl_t                        ctrl,
  output logic [DIGIT_W*(DIGITS+2)-1:0]  product
);

  localparam int W  = DIGITS + 2;
  localparam int BW = DIGIT_W * W;

  logic [BW-1:0] xWide, x2, x5, x10;
  logic [BW-1:0] upTerm, loMag, loTerm, sumVal;
  logic [W:0]    dblCy;
  logic [W:0]    addCy;

  assign xWide    = {{(2*DIGIT_W){1'b0}}, multiplicand};
  assign x10      = {xWide[BW-DIGIT_W-1:0], {DIGIT_W{1'b0}}};
  assign dblCy[0] = 1'b0;
  assign addCy[0] = ctrl.loNeg;

  for (genvar i = 0; i < W; i++) begin : gDigit
    logic [3:0] curDig, dblLow, halfLow, prevHalf;
    logic [4:0] addRaw;
    logic       addBig;

    assign curDig = xWide[DIGIT_W*i +: DIGIT_W];

    // doubling: even low part plus incoming carry, never re-carries
    assign dblLow       = (curDig >= 4'd5) ? 4'((curDig << 1) - 4'd10) : 4'(curDig << 1);
    assign dblCy[i+1]   = (curDig >= 4'd5);
    assign x2[DIGIT_W*i +: DIGIT_W] = dblLow | {3'b000, dblCy[i]};

    // quintupling: five for an odd digit plus half the digit below
    if (i == 0) begin : gFirst
      assign prevHalf = 4'd0;
    end else begin : gRest
      assign prevHalf = {1'b0, xWide[DIGIT_W*(i-1)+1 +: 3]};
    end
    assign halfLow = curDig[0] ? 4'd5 : 4'd0;
    assign x5[DIGIT_W*i +: DIGIT_W] = halfLow + prevHalf;

    // conditional nine's complement of the lower magnitude
    assign loTerm[DIGIT_W*i +: DIGIT_W] =
      ctrl.loNeg ? 4'(4'd9 - loMag[DIGIT_W*i +: DIGIT_W]) : loMag[DIGIT_W*i +: DIGIT_W];

    // decimal digit adder in the ripple chain
    assign addRaw = {1'b0, upTerm[DIGIT_W*i +: DIGIT_W]}
                  + {1'b0, loTerm[DIGIT_W*i +: DIGIT_W]}
                  + {4'b0000, addCy[i]};
    assign addBig     = (addRaw > 5'd9);
    assign addCy[i+1] = addBig;
    assign sumVal[DIGIT_W*i +: DIGIT_W] = addBig ? 4'(addRaw - 5'd10) : addRaw[3:0];
  end

  assign upTerm = ({BW{ctrl.upSel[1]}} & x5) | ({BW{ctrl.upSel[2]}} & x10);
  assign loMag  = ({BW{ctrl.loSel[1]}} & xWide) | ({BW{ctrl.loSel[2]}} & x2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) product <= '0;
    else       product <= sumVal;
  end

endmodule

// File: rtl/decimal_pp_gen.sv
module decimal_pp_gen #(
  parameter int DIGITS = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [4*DIGITS-1:0]     multiplicand,
  input  logic [3:0]              digit,
  output logic [4*(DIGITS+2)-1:0] product
);

  ppgen_pkg::ppCtrl_t ctrl;

  ppgen_recode u_recode (
    .digit (digit),
    .ctrl  (ctrl)
  );

  ppgen_datapath #(.DIGITS(DIGITS)) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .multiplicand (multiplicand),
    .ctrl         (ctrl),
    .product      (product)
  );

endmodule

// File: rtl/decimal_pp_gen_chk.sv
module decimal_pp_gen_chk
  import ppgen_pkg::*;
#(
  parameter int DIGITS = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [4*DIGITS-1:0]     multiplicand,
  input logic [3:0]              digit,
  input logic [4*(DIGITS+2)-1:0] product,
  input ppCtrl_t                 ctrl
);

  localparam int W = DIGITS + 2;

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  for (genvar i = 0; i < W; i++) begin : gBcd
    p_bcd_digit_r3: assert property (@(posedge clk) disable iff (!rstN)
      product[4*i +: 4] <= 4'd9);
  end

  p_top_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    product[4*W-1 -: 4] == 4'd0);

  p_ctrl_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(ctrl.upSel) && $onehot(ctrl.loSel));

  p_neg_nonzero_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loNeg |-> !ctrl.loSel[0]);

  p_zero_digit_r6: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(digit) == 4'd0) |-> product == '0);

  p_identity_r7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(digit) == 4'd1) |-> product == {8'h00, $past(multiplicand)});

  p_bad_digit_r11: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(digit) > 4'd9) |-> product == '0);

endmodule

bind decimal_pp_gen decimal_pp_gen_chk #(.DIGITS(DIGITS)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .multiplicand (multiplicand),
  .digit        (digit),
  .product      (product),
  .ctrl         (ctrl)
);

// File: tb/tb_decimal_pp_gen.sv
module tb_decimal_pp_gen;

  localparam int DIGITS = 3;
  localparam int W      = DIGITS + 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [4*DIGITS-1:0] multiplicand = '0;
  logic [3:0]        digit = '0;
  logic [4*W-1:0]    product;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  decimal_pp_gen #(.DIGITS(DIGITS)) dut (
    .clk          (clk),
    .rstN         (rstN),
    .multiplicand (multiplicand),
    .digit        (digit),
    .product      (product)
  );

  function automatic logic [4*W-1:0] toBcd(input int value);
    logic [4*W-1:0] r;
    int v;
    v = value;
    r = '0;
    for (int k = 0; k < W; k++) begin
      r[4*k +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [4*W-1:0] got, input logic [4*W-1:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: X=%0h Y=%0d got %h expected %h", tag, multiplicand, digit, got, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    string tag;
    logic [4*W-1:0] exp;
    logic digitsOk;
    multiplicand = 12'h999;
    digit = 4'd9;
    repeat (3) @(negedge clk);
    check("R2", product, '0);  // held at zero in reset
    rstN = 1'b1;

    for (int x = 0; x < 1000; x++) begin
      for (int y = 0; y < 16; y++) begin
        multiplicand = toBcd(x)[4*DIGITS-1:0];
        digit = 4'(y);
        @(negedge clk);
        if (y > 9)                    begin tag = "R11"; exp = '0; end
        else begin
          exp = toBcd(x * y);
          if (y == 0)                 tag = "R6";
          else if (y == 1)            tag = "R7";
          else if (y == 2 && x == 999) tag = "R9";
          else if (y == 5 && x == 999) tag = "R10";
          else if (y == 8 || y == 9)  tag = "R4";
          else if (y == 3 || y == 4)  tag = "R5";
          else                        tag = "R1";
        end
        check(tag, product, exp);
        if (x == 999) begin
          digitsOk = 1'b1;
          for (int k = 0; k < W; k++) if (product[4*k +: 4] > 4'd9) digitsOk = 1'b0;
          check("R3", {{(4*W-1){1'b0}}, digitsOk}, {{(4*W-1){1'b0}}, 1'b1});
          check("R8", {{(4*W-4){1'b0}}, product[4*W-1 -: 4]}, '0);
        end
      end
    end
    summary();
  end

endmodule